// File: doc/BRIEF.md
# Cartridge Bus Decoder and Bank Latch

This block watches an 8-bit CPU bus and generates the chip selects a cartridge needs. The bus carries a phase-2 enable (`m2`), an active-low write line (`cpu_rw`, low means the CPU drives write data), a 16-bit address and an 8-bit data bus. The upper 32 KiB of the address space is ROM. The ROM chip enable follows the plain address-and-phase decode. The ROM output enable is also qualified by read cycles, so the cartridge never drives the bus while the CPU is writing. The lowest 8 KiB is work RAM. It gets a chip enable, a write strobe that follows the write line, and an output enable that stays active.

The block also keeps a small bank register. A CPU write into the ROM range loads it, but only when the write line is low during the high phase of `m2`. All bus inputs are sampled on a fast system clock `clk`. The register takes the data that was present in the last `clk` sample of the high phase, and the load happens at the first `clk` edge that sees `m2` low again. This matches the moment the CPU ends a write cycle, before it moves the address lines. Dummy cycles, reads and address changes while `m2` is low leave the register alone.

Top module: `cbd_cart_bus`

## Requirements
- R1: Out of reset, `rom_ce_n` is 0 exactly when `cpu_addr[15]` is 1 and `m2` is 1, whatever the value of `cpu_rw`.
- R2: Out of reset, `rom_oe_n` is 0 exactly when `cpu_addr[15]` is 1, `m2` is 1 and `cpu_rw` is 1 (read).
- R3: Out of reset, `wram_ce_n` is 0 exactly when `cpu_addr[15:13]` is 3'b000 and `m2` is 1.
- R4: Out of reset, `wram_we_n` is 0 exactly when `wram_ce_n` is 0 and `cpu_rw` is 0, and `wram_oe_n` is held at 0.
- R5: While `m2` is 0, none of `rom_ce_n`, `rom_oe_n`, `wram_ce_n` or `wram_we_n` is asserted (all are 1), for any address and any `cpu_rw`.
- R6: When the last `clk` sample with `m2` high had `cpu_addr[15]`=1 and `cpu_rw`=0, `bank` takes that sample's `cpu_data[2:0]` at the first `clk` edge that samples `m2` low.
- R7: Reads of any region, writes below 0x8000, and address, data or `cpu_rw` activity while `m2` stays low leave `bank` unchanged.
- R8: If `cpu_data` changes while `m2` is high during a ROM-range write, `bank` takes the value present in the last `clk` sample before `m2` falls.
- R9: While `rst_n` is 0 (a synchronous, active-low reset), all five select outputs are 1. At the next `clk` edge `bank` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, much faster than `m2` |
| rst_n | input | 1 | Synchronous active-low reset |
| m2 | input | 1 | CPU phase-2 bus enable, high during the active part of a cycle |
| cpu_rw | input | 1 | 1 = read, 0 = CPU drives write data |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus, as seen by the cartridge |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable qualified by read, active low |
| wram_ce_n | output | 1 | Work RAM chip enable, active low |
| wram_we_n | output | 1 | Work RAM write strobe, active low |
| wram_oe_n | output | 1 | Work RAM output enable, active low, held active out of reset |
| bank | output | 3 | Latched bank number |

## Verification
On every cycle the assertions check the bus-safety properties. No select asserts while `m2` is low. The ROM output enable never asserts on a write or without the ROM chip enable. The RAM enable stays inside its 8 KiB window. The bank value moves only at a falling phase edge. The reset state is checked too. Other behaviours depend on sequences of bus cycles, and only the bench scenarios show them. These are the value that is captured when data changes mid-phase, the register being untouched by reads, RAM writes and writes made with `m2` low, and the bank surviving a long random mix of regions.

// File: rtl/cbd_pkg.sv
// Package: shared widths and region constants for the cartridge bus decoder.
// Assumes a 16-bit CPU address space with ROM in the upper half.
package cbd_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int BANK_W    = 3;
    localparam int RAM_LOG2  = 13;   // 8 KiB work RAM window at the bottom

    // Decoded region of one bus sample
    typedef struct packed {
        logic rom_hit;   // address in upper half
        logic ram_hit;   // address in bottom RAM window
    } cbd_region_t;
endpackage

// File: rtl/cbd_addr_decode.sv
// Module: cbd_addr_decode
// Classifies an address into the ROM half and the low RAM window.
// Assumes the ROM occupies the top half (MSB set) and the RAM window is 2**RAM_LOG2 bytes from 0.
module cbd_addr_decode
    import cbd_pkg::*;
#(
    parameter int AW       = ADDR_W,
    parameter int RAM_BITS = RAM_LOG2
) (
    input  logic [AW-1:0] addr,
    output cbd_region_t   region
);
    localparam int HI_W = AW - RAM_BITS;

    // Combinational region classification
    always_comb begin
        region.rom_hit = addr[AW-1];
        region.ram_hit = (addr[AW-1 -: HI_W] == '0);
    end
endmodule

// File: rtl/cbd_select_gen.sv
// Module: cbd_select_gen
// Qualifies decoded regions with the bus phase, the write line and reset to form active-low selects.
// Assumes the inputs are the live bus lines. The outputs are combinational and drive no state.
module cbd_select_gen
    import cbd_pkg::*;
(
    input  logic        rst_n,
    input  logic        m2,
    input  logic        cpu_rw,
    input  cbd_region_t region,
    output logic        rom_ce_n,
    output logic        rom_oe_n,
    output logic        wram_ce_n,
    output logic        wram_we_n,
    output logic        wram_oe_n
);
    logic active;
    logic rom_sel;
    logic ram_sel;

    // Form phase-qualified selects; reset forces every select inactive
    always_comb begin
        active    = rst_n & m2;
        rom_sel   = active & region.rom_hit;
        ram_sel   = active & region.ram_hit;
        rom_ce_n  = ~rom_sel;
        rom_oe_n  = ~(rom_sel & cpu_rw);
        wram_ce_n = ~ram_sel;
        wram_we_n = ~(ram_sel & ~cpu_rw);
        wram_oe_n = ~rst_n;
    end
endmodule

// File: rtl/cbd_bank_latch.sv
// Module: cbd_bank_latch
// Holds the bank number. It remembers the last sample taken during the M2-high phase and commits it at the falling phase edge.
// Assumes clk is several times faster than m2, so each high phase spans at least one clk sample.
module cbd_bank_latch
    import cbd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int BW = BANK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m2,
    input  logic          cpu_rw,
    input  logic          rom_hit,
    input  logic [DW-1:0] cpu_data,
    output logic [BW-1:0] bank
);
    logic          m2_q;
    logic          pend_wr;
    logic [BW-1:0] pend_val;
    logic          m2_fall;

    // Falling phase edge: previous sample high, present sample low
    always_comb m2_fall = m2_q & ~m2;

    // Track the phase level from the previous clk sample
    always_ff @(posedge clk) begin
        if (!rst_n) m2_q <= 1'b0;
        else        m2_q <= m2;
    end

    // Keep the most recent high-phase sample of write intent and data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_wr  <= 1'b0;
            pend_val <= '0;
        end else if (m2) begin
            pend_wr  <= rom_hit & ~cpu_rw;
            pend_val <= cpu_data[BW-1:0];
        end
    end

    // Commit a qualified ROM-range write at the end of the high phase
    always_ff @(posedge clk) begin
        if (!rst_n)                 bank <= '0;
        else if (m2_fall && pend_wr) bank <= pend_val;
    end
endmodule

// File: rtl/cbd_cart_bus.sv
// Module: cbd_cart_bus (top)
// Cartridge-side bus decoder: ROM and work-RAM selects plus a write-qualified bank latch.
// Assumes synchronous active-low reset and bus lines that are stable around each clk edge.
module cbd_cart_bus
    import cbd_pkg::*;
#(
    parameter int AW       = ADDR_W,
    parameter int DW       = DATA_W,
    parameter int BW       = BANK_W,
    parameter int RAM_BITS = RAM_LOG2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m2,
    input  logic          cpu_rw,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_data,
    output logic          rom_ce_n,
    output logic          rom_oe_n,
    output logic          wram_ce_n,
    output logic          wram_we_n,
    output logic          wram_oe_n,
    output logic [BW-1:0] bank
);
    cbd_region_t region;

    cbd_addr_decode #(.AW(AW), .RAM_BITS(RAM_BITS)) u_dec (
        .addr   (cpu_addr),
        .region (region)
    );

    cbd_select_gen u_sel (
        .rst_n     (rst_n),
        .m2        (m2),
        .cpu_rw    (cpu_rw),
        .region    (region),
        .rom_ce_n  (rom_ce_n),
        .rom_oe_n  (rom_oe_n),
        .wram_ce_n (wram_ce_n),
        .wram_we_n (wram_we_n),
        .wram_oe_n (wram_oe_n)
    );

    cbd_bank_latch #(.DW(DW), .BW(BW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .m2       (m2),
        .cpu_rw   (cpu_rw),
        .rom_hit  (region.rom_hit),
        .cpu_data (cpu_data),
        .bank     (bank)
    );
endmodule

// File: rtl/cbd_cart_bus_chk.sv
// Module: cbd_cart_bus_chk
// Port-level checker bound to cbd_cart_bus. It watches select safety, the region windows, when the bank may move, and reset.
module cbd_cart_bus_chk #(
    parameter int AW = 16,
    parameter int BW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          m2,
    input logic          cpu_rw,
    input logic [AW-1:0] cpu_addr,
    input logic          rom_ce_n,
    input logic          rom_oe_n,
    input logic          wram_ce_n,
    input logic          wram_we_n,
    input logic          wram_oe_n,
    input logic [BW-1:0] bank
);
    logic m2_d;

    // Previous-sample phase level, reset to low
    always_ff @(posedge clk) begin
        if (!rst_n) m2_d <= 1'b0;
        else        m2_d <= m2;
    end

    a_r5_idle_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        !m2 |-> (rom_ce_n && rom_oe_n && wram_ce_n && wram_we_n));

    a_r2_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> (cpu_rw && !rom_ce_n));

    a_r3_ram_window: assert property (@(posedge clk) disable iff (!rst_n)
        !wram_ce_n |-> (cpu_addr[AW-1 -: 3] == 3'b000));

    a_r4_we_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !wram_we_n |-> (!wram_ce_n && !cpu_rw));

    a_r1_ce_rom_half: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_ce_n |-> (cpu_addr[AW-1] && m2));

    a_r7_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (m2 || !m2_d) |=> $stable(bank));

    a_r9_reset_selects: assert property (@(posedge clk)
        !rst_n |-> (rom_ce_n && rom_oe_n && wram_ce_n && wram_we_n && wram_oe_n));

    a_r9_reset_bank: assert property (@(posedge clk)
        !rst_n |=> (bank == '0));
endmodule

bind cbd_cart_bus cbd_cart_bus_chk #(.AW(AW), .BW(BW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .m2        (m2),
    .cpu_rw    (cpu_rw),
    .cpu_addr  (cpu_addr),
    .rom_ce_n  (rom_ce_n),
    .rom_oe_n  (rom_oe_n),
    .wram_ce_n (wram_ce_n),
    .wram_we_n (wram_we_n),
    .wram_oe_n (wram_oe_n),
    .bank      (bank)
);

// File: tb/cbd_cart_bus_bench.sv
// Bench for cbd_cart_bus: directed corner cases plus seeded random bus cycles.
module cbd_cart_bus_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        m2;
    logic        cpu_rw;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_data;
    logic        rom_ce_n, rom_oe_n, wram_ce_n, wram_we_n, wram_oe_n;
    logic [2:0]  bank;

    int n_chk  = 0;
    int n_fail = 0;
    logic [2:0] exp_bank;

    always #10 clk = ~clk;   // 50 MHz

    cbd_cart_bus u_cbd_cart_bus (
        .clk(clk), .rst_n(rst_n), .m2(m2), .cpu_rw(cpu_rw),
        .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .wram_ce_n(wram_ce_n),
        .wram_we_n(wram_we_n), .wram_oe_n(wram_oe_n), .bank(bank)
    );

    // Expected select vector {rom_ce_n, rom_oe_n, wram_ce_n, wram_we_n, wram_oe_n}
    function automatic logic [4:0] exp_sel(input logic rst, input logic ph,
                                           input logic rw, input logic [15:0] a);
        logic rom, ram;
        rom = rst && ph && a[15];
        ram = rst && ph && (a[15:13] == 3'b000);
        return {~rom, ~(rom && rw), ~ram, ~(ram && !rw), ~rst};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_sel(input string req);
        chk(req, {27'd0, rom_ce_n, rom_oe_n, wram_ce_n, wram_we_n, wram_oe_n},
            {27'd0, exp_sel(rst_n, m2, cpu_rw, cpu_addr)});
    endtask

    // One bus cycle: low phase, two clk samples high, fall, then check the bank
    task automatic bus_cycle(input logic [15:0] a, input logic rw, input logic [7:0] d,
                             input logic [7:0] d_late);
        @(negedge clk); cpu_addr = a; cpu_rw = rw; cpu_data = d; m2 = 1'b0;
        #1 chk_sel("R5 idle phase");
        @(negedge clk); m2 = 1'b1;
        #1 chk_sel("R1/R2/R3/R4 active phase");
        @(negedge clk); cpu_data = d_late;
        #1 chk_sel("R1/R2/R3/R4 active phase late");
        @(negedge clk); m2 = 1'b0;
        if (a[15] && !rw) exp_bank = d_late[2:0];
        @(negedge clk);
        #1 chk("R6/R7/R8 bank after cycle", {29'd0, bank}, {29'd0, exp_bank});
    endtask

    // Watchdog
    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h0C0FFEE5));
        rst_n = 1'b0; m2 = 1'b0; cpu_rw = 1'b1; cpu_addr = 16'h8000; cpu_data = 8'h00;
        exp_bank = 3'd0;
        @(negedge clk); m2 = 1'b1;
        #1 chk_sel("R9 selects in reset");
        @(negedge clk); m2 = 1'b0;
        #1 chk("R9 bank in reset", {29'd0, bank}, 32'd0);
        rst_n = 1'b1;

        // R6 direct ROM-range write, R2 write must not enable ROM output
        bus_cycle(16'h8000, 1'b0, 8'h05, 8'h05);
        bus_cycle(16'hFFFF, 1'b0, 8'hFA, 8'hFA);
        // R7 reads and RAM writes leave the bank
        bus_cycle(16'hC123, 1'b1, 8'h07, 8'h07);
        bus_cycle(16'h1FFF, 1'b0, 8'h01, 8'h01);
        bus_cycle(16'h7FFF, 1'b0, 8'h03, 8'h03);
        bus_cycle(16'h2000, 1'b1, 8'h04, 8'h04);
        // R8 data changes mid-phase: last sample wins
        bus_cycle(16'hA000, 1'b0, 8'h06, 8'h01);

        // R7 write-looking activity while m2 stays low
        @(negedge clk); cpu_addr = 16'h9000; cpu_rw = 1'b0; cpu_data = 8'h07; m2 = 1'b0;
        #1 chk_sel("R5 write with phase low");
        @(negedge clk); cpu_data = 8'h02;
        @(negedge clk); cpu_addr = 16'h0000;
        #1 chk_sel("R5 RAM write with phase low");
        @(negedge clk);
        #1 chk("R7 bank after phase-low write", {29'd0, bank}, {29'd0, exp_bank});

        // Random mix across regions
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a;
            logic [7:0]  d, d2;
            logic        rw;
            case ($urandom % 3)
                0: a = 16'h8000 | 16'($urandom % 32768);
                1: a = 16'($urandom % 8192);
                default: a = 16'h2000 + 16'($urandom % 24576);
            endcase
            rw = 1'($urandom);
            d  = 8'($urandom);
            d2 = (($urandom % 4) == 0) ? 8'($urandom) : d;
            bus_cycle(a, rw, d, d2);
        end

        // R9 mid-run reset clears the bank and the selects
        bus_cycle(16'h8001, 1'b0, 8'h07, 8'h07);
        @(negedge clk); rst_n = 1'b0; m2 = 1'b1; cpu_addr = 16'h0010; cpu_rw = 1'b0;
        #1 chk_sel("R9 selects during reset");
        @(negedge clk); m2 = 1'b0;
        #1 chk("R9 bank cleared", {29'd0, bank}, 32'd0);
        rst_n = 1'b1; exp_bank = 3'd0;
        bus_cycle(16'hE000, 1'b1, 8'h03, 8'h03);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule